// File: doc/BRIEF.md
# SPI Mode-3 Slave Transmit Buffer

This block is a synchronous SPI slave with clock polarity 1 and phase 1. Local logic pushes bytes into an internal transmit queue through a one-cycle write strobe. An external master reads them out over MISO while a select line is held low. Outgoing bits change after falling SCLK edges and are meant to be sampled by the master on rising edges. The slave samples MOSI on those same rising edges and presents each completed byte with a one-cycle strobe. SCLK, the select line and MOSI are treated as asynchronous: each passes through a two-flop synchronizer into the system clock domain. The system clock must run at least four times faster than SCLK.

Selection depends on the select level, not on a select edge. Any time the synchronized select is high, the bit counter and both shift registers return to their idle state, so the next low period always starts on a byte boundary. This is how a master recovers bit alignment after a glitch. When the queue is empty the slave shifts out zero bytes. A data-ready output is high while the queue holds at least one byte. A write that finds the queue full discards the whole queue, and a sticky flag records that event until local logic clears it.

Top module: `spi3_slave_tx`

## Requirements
- R1: While reset is asserted and in the cycle after it, `spi_miso`, `data_rdy`, `rx_valid` and `ovf_flag` are all 0.
- R2: Bytes leave MSB first on MISO. MISO changes only in response to a synchronized falling SCLK edge or a change of the synchronized select. MOSI is sampled on synchronized rising edges.
- R3: A select that is already low when reset is released enables transfers; no falling edge of `spi_cs_n` is required.
- R4: While the synchronized select is high, MISO is 0 and the bit counter is cleared. A byte left partly shifted is abandoned, and the next transfer starts with a fresh byte from the queue.
- R5: A byte slot that starts while the queue is empty shifts out 0x00.
- R6: The queue holds DEPTH bytes (default 4096) and returns them in write order. A write to a queue holding fewer than DEPTH bytes never loses data.
- R7: A write while the queue holds DEPTH bytes empties the queue and drops the written byte. `data_rdy` is 0 in the following cycle, and later slots send 0x00.
- R8: `data_rdy` is 1 exactly when the queue is not empty.
- R9: After the eighth synchronized rising edge of a byte, `rx_valid` is high for one cycle with the received byte (first bit in bit 7) on `rx_byte`. `rx_byte` holds that value afterwards.
- R10: `ovf_flag` is set by a discarding write and stays set until `ovf_clear`. When a discarding write and `ovf_clear` occur in the same cycle, the flag is set.
- R11: The next byte is taken from the queue at the first falling SCLK edge after the previous byte's eighth sample, or at the first falling edge of a select-low period. Toggling select without clocking removes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCLK |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Push `wr_byte` into the transmit queue |
| wr_byte | input | 8 | Byte to queue |
| ovf_clear | input | 1 | Clears the overflow flag |
| spi_sclk | input | 1 | SPI clock from master, idles high |
| spi_cs_n | input | 1 | Active-low select from master |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| data_rdy | output | 1 | Queue not empty, active high |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_byte | output | 8 | Last received byte |
| ovf_flag | output | 1 | Sticky flag set by a queue discard |

## Verification
The hardest case to reach is the discard on a full write. The queue is deep, and it drains whenever the master clocks. The bench keeps SCLK idle high and streams DEPTH back-to-back writes, reads two bytes to confirm order, refills to exactly full, and then writes once more. It repeats this with `ovf_clear` raised in the discarding cycle. Loss of bit alignment is provoked by clocking three bits, raising select and then checking that the next full byte comes from the following queue entry.

// File: rtl/spi3_pkg.sv
`timescale 1ns/1ps
package spi3_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CNT_W  = $clog2(BYTE_W);

    typedef logic [BYTE_W-1:0] byte_t;

    // Serial engine state
    typedef struct packed {
        logic             sclk_prev;
        logic [CNT_W-1:0] bit_cnt;
        logic             load_pend;
        byte_t            tx_sr;
        byte_t            rx_sr;
        logic             rx_stb;
        byte_t            rx_out;
    } shift_st_t;
endpackage

// File: rtl/spi3_sync.sv
`timescale 1ns/1ps
module spi3_sync #(
    parameter int unsigned    W    = 3,
    parameter logic [W-1:0]   INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [1:0] stage_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= {2{INIT[i]}};
            else        stage_q <= {stage_q[0], din[i]};
        end
        assign dout[i] = stage_q[1];
    end
endmodule

// File: rtl/spi3_fifo.sv
`timescale 1ns/1ps
module spi3_fifo
    import spi3_pkg::*;
#(
    parameter int unsigned DEPTH = 4096
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  byte_t wr_data,
    input  logic  rd_en,
    output byte_t rd_data,
    output logic  empty,
    output logic  full,
    output logic  flush
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [AW:0]   count;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    byte_t    mem [DEPTH];
    logic     push, pop;

    assign full    = (st_q.count == FULL_CNT);
    assign empty   = (st_q.count == '0);
    assign flush   = wr_en & full;
    assign push    = wr_en & ~full;
    assign pop     = rd_en & ~empty;
    assign rd_data = mem[st_q.rd_ptr];

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.rd_ptr = st_q.wr_ptr;
            st_d.count  = '0;
        end else begin
            if (push) st_d.wr_ptr = st_q.wr_ptr + 1'b1;
            if (pop)  st_d.rd_ptr = st_q.rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   st_d.count = st_q.count + 1'b1;
                2'b01:   st_d.count = st_q.count - 1'b1;
                default: st_d.count = st_q.count;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[st_q.wr_ptr] <= wr_data;
    end
endmodule

// File: rtl/spi3_shifter.sv
`timescale 1ns/1ps
module spi3_shifter
    import spi3_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sclk_s,
    input  logic  cs_s,
    input  logic  mosi_s,
    input  byte_t fill_byte,
    output logic  pop,
    output logic  fall_o,
    output logic  miso,
    output logic  rx_stb,
    output byte_t rx_out
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    shift_st_t st_d, st_q;
    logic      rise, fall;
    byte_t     rx_shift;

    assign rise     = sclk_s & ~st_q.sclk_prev;
    assign fall     = ~sclk_s & st_q.sclk_prev;
    assign rx_shift = {st_q.rx_sr[BYTE_W-2:0], mosi_s};
    assign pop      = ~cs_s & fall & st_q.load_pend;
    assign fall_o   = fall;
    assign miso     = ~cs_s & st_q.tx_sr[BYTE_W-1];
    assign rx_stb   = st_q.rx_stb;
    assign rx_out   = st_q.rx_out;

    always_comb begin
        st_d           = st_q;
        st_d.rx_stb    = 1'b0;
        st_d.sclk_prev = sclk_s;
        if (cs_s) begin
            st_d.bit_cnt   = '0;
            st_d.load_pend = 1'b1;
            st_d.tx_sr     = '0;
            st_d.rx_sr     = '0;
        end else begin
            if (fall) begin
                if (st_q.load_pend) begin
                    st_d.tx_sr     = fill_byte;
                    st_d.load_pend = 1'b0;
                end else begin
                    st_d.tx_sr = {st_q.tx_sr[BYTE_W-2:0], 1'b0};
                end
            end
            if (rise) begin
                st_d.rx_sr = rx_shift;
                if (st_q.bit_cnt == LAST) begin
                    st_d.bit_cnt   = '0;
                    st_d.load_pend = 1'b1;
                    st_d.rx_stb    = 1'b1;
                    st_d.rx_out    = rx_shift;
                end else begin
                    st_d.bit_cnt = st_q.bit_cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.sclk_prev <= 1'b1;
            st_q.load_pend <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/spi3_slave_tx.sv
`timescale 1ns/1ps
module spi3_slave_tx
    import spi3_pkg::*;
#(
    parameter int unsigned DEPTH = 4096
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_valid,
    input  logic [7:0]  wr_byte,
    input  logic        ovf_clear,
    input  logic        spi_sclk,
    input  logic        spi_cs_n,
    input  logic        spi_mosi,
    output logic        spi_miso,
    output logic        data_rdy,
    output logic        rx_valid,
    output logic [7:0]  rx_byte,
    output logic        ovf_flag
);
    typedef struct packed {
        logic ovf;
    } top_st_t;

    logic    sclk_sync, cs_sync, mosi_sync, sclk_fall;
    logic    fifo_pop, fifo_empty, fifo_full, fifo_flush;
    byte_t   fifo_rd_data, fill_byte;
    top_st_t st_d, st_q;

    spi3_sync #(.W(3), .INIT(3'b011)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({spi_mosi, spi_cs_n, spi_sclk}),
        .dout ({mosi_sync, cs_sync, sclk_sync})
    );

    spi3_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_valid),
        .wr_data(wr_byte),
        .rd_en  (fifo_pop),
        .rd_data(fifo_rd_data),
        .empty  (fifo_empty),
        .full   (fifo_full),
        .flush  (fifo_flush)
    );

    assign fill_byte = fifo_empty ? '0 : fifo_rd_data;

    spi3_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (sclk_sync),
        .cs_s     (cs_sync),
        .mosi_s   (mosi_sync),
        .fill_byte(fill_byte),
        .pop      (fifo_pop),
        .fall_o   (sclk_fall),
        .miso     (spi_miso),
        .rx_stb   (rx_valid),
        .rx_out   (rx_byte)
    );

    always_comb begin
        st_d = st_q;
        if (fifo_flush)     st_d.ovf = 1'b1;
        else if (ovf_clear) st_d.ovf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ovf_flag = st_q.ovf;
    assign data_rdy = ~fifo_empty;
endmodule

// File: rtl/spi3_slave_tx_chk.sv
`timescale 1ns/1ps
module spi3_slave_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_valid,
    input logic ovf_clear,
    input logic fifo_full,
    input logic data_rdy,
    input logic ovf_flag,
    input logic rx_valid,
    input logic spi_miso,
    input logic cs_sync,
    input logic sclk_fall
);
    AST_RDY_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !fifo_full |=> data_rdy);                                 // R8
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && fifo_full |=> !data_rdy);                                 // R7
    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(wr_valid && fifo_full));                    // R7
    AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag && !ovf_clear |=> ovf_flag);                                 // R10
    AST_OVF_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && fifo_full && ovf_clear |=> ovf_flag);                     // R10
    AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);                                              // R9
    AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cs_sync |-> !spi_miso);                                               // R4
    AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(spi_miso) |-> ($past(sclk_fall) || !$stable(cs_sync)));      // R2
endmodule

bind spi3_slave_tx spi3_slave_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .ovf_clear(ovf_clear),
    .fifo_full(fifo_full),
    .data_rdy (data_rdy),
    .ovf_flag (ovf_flag),
    .rx_valid (rx_valid),
    .spi_miso (spi_miso),
    .cs_sync  (cs_sync),
    .sclk_fall(sclk_fall)
);

// File: tb/tb_spi3_slave_tx.sv
`timescale 1ns/1ps
module tb_spi3_slave_tx;
    localparam int DEPTH = 4096;
    localparam int HALF  = 4;

    logic       clk = 1'b0;
    logic       rst_n, wr_valid, ovf_clear, spi_sclk, spi_cs_n, spi_mosi;
    logic [7:0] wr_byte;
    logic       spi_miso, data_rdy, rx_valid, ovf_flag;
    logic [7:0] rx_byte;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    spi3_slave_tx #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_byte(wr_byte),
        .ovf_clear(ovf_clear), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .data_rdy(data_rdy),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .ovf_flag(ovf_flag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic       m_sc1, m_sc2, m_cs1, m_cs2, m_mo1, m_mo2, m_prev;
    int         m_cnt;
    logic       m_pend, m_rxv, m_ovf, m_live;
    logic [7:0] m_tx, m_rx, m_rxb;
    logic [7:0] m_q[$];

    always @(posedge clk) begin : model
        logic rise, fall, take, flush;
        logic [7:0] head;
        if (!rst_n) begin
            m_sc1 = 1; m_sc2 = 1; m_cs1 = 1; m_cs2 = 1; m_mo1 = 0; m_mo2 = 0;
            m_prev = 1; m_cnt = 0; m_pend = 1; m_rxv = 0; m_ovf = 0;
            m_tx = 0; m_rx = 0; m_rxb = 0; m_q.delete(); m_live = 0;
        end else begin
            m_live = 1;
            rise = m_sc2 && !m_prev;
            fall = !m_sc2 && m_prev;
            head = (m_q.size() > 0) ? m_q[0] : 8'h00;
            take = !m_cs2 && fall && m_pend;
            m_rxv = 0;
            if (m_cs2) begin
                m_cnt = 0; m_pend = 1; m_tx = 0; m_rx = 0;
            end else begin
                if (fall) begin
                    if (m_pend) begin m_tx = head; m_pend = 0; end
                    else m_tx = m_tx << 1;
                end
                if (rise) begin
                    m_rx = {m_rx[6:0], m_mo2};
                    if (m_cnt == 7) begin
                        m_cnt = 0; m_pend = 1; m_rxv = 1; m_rxb = m_rx;
                    end else m_cnt++;
                end
            end
            flush = wr_valid && (m_q.size() == DEPTH);
            if (flush) begin
                m_q.delete(); m_ovf = 1;
            end else begin
                if (take && m_q.size() > 0) void'(m_q.pop_front());
                if (wr_valid) m_q.push_back(wr_byte);
                if (ovf_clear) m_ovf = 0;
            end
            m_prev = m_sc2;
            m_sc2 = m_sc1; m_sc1 = spi_sclk;
            m_cs2 = m_cs1; m_cs1 = spi_cs_n;
            m_mo2 = m_mo1; m_mo1 = spi_mosi;
        end
    end

    always @(negedge clk) begin
        if (rst_n && m_live && !done) begin
            chk(spi_miso == (!m_cs2 && m_tx[7]), "R2 miso", spi_miso, !m_cs2 && m_tx[7]);
            chk(data_rdy == (m_q.size() != 0), "R8 data_rdy", data_rdy, m_q.size() != 0);
            chk(rx_valid == m_rxv, "R9 rx_valid", rx_valid, m_rxv);
            if (m_rxv) chk(rx_byte == m_rxb, "R9 rx_byte", rx_byte, m_rxb);
            chk(ovf_flag == m_ovf, "R10 ovf_flag", ovf_flag, m_ovf);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [7:0] b);
        wr_valid = 1'b1; wr_byte = b;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] out_b, output logic [7:0] in_b);
        for (int i = 7; i >= 0; i--) begin
            spi_sclk = 1'b0; spi_mosi = out_b[i];
            wait_clk(HALF);
            in_b[i] = spi_miso;
            spi_sclk = 1'b1;
            wait_clk(HALF);
        end
    endtask

    task automatic xfer_exp(input logic [7:0] out_b, input logic [7:0] exp_b, input string req);
        logic [7:0] got;
        xfer(out_b, got);
        chk(got === exp_b, req, got, exp_b);
        wait_clk(HALF);
        chk(rx_byte === out_b, "R9 received byte", rx_byte, out_b);
    endtask

    task automatic fill_queue();
        wr_valid = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            wr_byte = i[7:0];
            @(negedge clk);
        end
        wr_valid = 1'b0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        rst_n = 0; wr_valid = 0; wr_byte = 0; ovf_clear = 0;
        spi_sclk = 1; spi_cs_n = 0; spi_mosi = 0;   // R3: select low from the start
        wait_clk(5);
        chk(spi_miso == 0, "R1 miso in reset", spi_miso, 0);
        chk(data_rdy == 0, "R1 data_rdy in reset", data_rdy, 0);
        chk(rx_valid == 0, "R1 rx_valid in reset", rx_valid, 0);
        chk(ovf_flag == 0, "R1 ovf_flag in reset", ovf_flag, 0);
        rst_n = 1;
        wait_clk(1);
        chk(!spi_miso && !data_rdy && !rx_valid && !ovf_flag, "R1 after reset",
            {spi_miso, data_rdy, rx_valid, ovf_flag}, 0);
        wait_clk(4);

        // R3 / R5: no select edge, empty queue -> zeros
        xfer_exp(8'h5A, 8'h00, "R3 R5 empty slot");

        // R2 / R6 / R8: ordered bytes then zero
        push(8'hA5); push(8'h3C); push(8'hF0);
        wait_clk(1);
        chk(data_rdy == 1, "R8 ready with data", data_rdy, 1);
        xfer_exp(8'h81, 8'hA5, "R2 R6 byte 0");
        xfer_exp(8'h42, 8'h3C, "R2 R6 byte 1");
        xfer_exp(8'hE7, 8'hF0, "R2 R6 byte 2");
        chk(data_rdy == 0, "R8 drained", data_rdy, 0);
        xfer_exp(8'h18, 8'h00, "R5 after drain");

        // R11: select toggle without clocks takes nothing
        push(8'h77);
        spi_cs_n = 1; wait_clk(6);
        spi_cs_n = 0; wait_clk(6);
        chk(data_rdy == 1, "R11 no pop on select toggle", data_rdy, 1);
        xfer_exp(8'h99, 8'h77, "R11 byte kept");

        // R4: partial byte then select high realigns
        push(8'h11); push(8'h22);
        for (int i = 0; i < 3; i++) begin
            spi_sclk = 0; spi_mosi = 1; wait_clk(HALF);
            spi_sclk = 1; wait_clk(HALF);
        end
        spi_cs_n = 1; wait_clk(6);
        chk(spi_miso == 0, "R4 miso idle while deselected", spi_miso, 0);
        spi_cs_n = 0; wait_clk(6);
        xfer_exp(8'hC3, 8'h22, "R4 realigned byte");
        chk(data_rdy == 0, "R4 queue drained", data_rdy, 0);

        // R6 / R7 / R10: capacity and discard
        fill_queue();
        wait_clk(1);
        chk(data_rdy == 1 && ovf_flag == 0, "R6 full without loss", {data_rdy, ovf_flag}, 2);
        xfer_exp(8'h00, 8'h00, "R6 order first");
        xfer_exp(8'h00, 8'h01, "R6 order second");
        push(8'hAA); push(8'hBB);
        wait_clk(1);
        chk(ovf_flag == 0, "R6 refill to exactly full", ovf_flag, 0);
        push(8'h99);
        chk(data_rdy == 0, "R7 discard empties queue", data_rdy, 0);
        chk(ovf_flag == 1, "R10 flag set", ovf_flag, 1);
        xfer_exp(8'h3E, 8'h00, "R7 zeros after discard");
        wait_clk(3);
        chk(ovf_flag == 1, "R10 flag sticky", ovf_flag, 1);
        ovf_clear = 1; wait_clk(1); ovf_clear = 0;
        chk(ovf_flag == 0, "R10 flag cleared", ovf_flag, 0);

        // R10: set wins over clear
        fill_queue();
        wr_valid = 1; wr_byte = 8'h55; ovf_clear = 1;
        wait_clk(1);
        wr_valid = 0; ovf_clear = 0;
        chk(ovf_flag == 1, "R10 set wins over clear", ovf_flag, 1);
        chk(data_rdy == 0, "R7 second discard", data_rdy, 0);
        ovf_clear = 1; wait_clk(1); ovf_clear = 0;
        chk(ovf_flag == 0, "R10 cleared again", ovf_flag, 0);
        wait_clk(4);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule